// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits next to the command path of an SDRAM controller and produces the column address for every data beat of a read or write burst. When a column-access command is issued, the block takes the starting column, a burst length code and a wrap type. From the next clock on, it presents one column per cycle, together with a beat-valid flag and a flag that marks the final beat.

Bursts of 1, 2, 4 or 8 beats stay inside the aligned segment of their own size. Only the low address bits move, and they move in either sequential or interleaved order. A full-page burst walks the whole 256-column page in sequential order and keeps wrapping until a stop or a new command arrives. A new command in the middle of a burst drops the remaining beats and begins again at full length. A stop input ends the burst at once. An illegal setting raises an error pulse and produces no beats.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `beat_valid_o`, `last_o` and `cfg_err_o` are low, and they stay low until a legal start is accepted.
- R2: A legal `start_i` sampled on a clock edge puts beat 0 on the outputs in the next cycle, with `col_o` equal to `start_col_i`. For `blen_i` codes 0, 1, 2 and 3 (lengths 1, 2, 4 and 8), `beat_valid_o` stays high for exactly that many consecutive cycles.
- R3: With `wrap_i` = 0 (sequential), beat n shows the start column's bits above the segment unchanged. The segment bits show (start + n) mod L, where L is the burst length.
- R4: With `wrap_i` = 1 (interleaved), beat n shows the start column's segment bits XOR n, and the upper bits are unchanged. For L = 8 and start 2 the order is 2, 3, 0, 1, 6, 7, 4, 5.
- R5: `last_o` is high on beat L-1 only, and only together with `beat_valid_o`. In the cycle after it, `beat_valid_o` is low unless a new start was sampled.
- R6: `blen_i` code 7 with sequential wrap selects full page. The column advances by one every cycle, modulo 256, with no end of its own, and `last_o` is never raised.
- R7: When `stop_i` is sampled without `start_i`, `beat_valid_o` is low from the next cycle and no further beats follow.
- R8: A legal `start_i` during a burst discards the remaining beats and begins a full-length burst at the new column. When `start_i` and `stop_i` arrive together, the start wins.
- R9: A start with code 7 and interleaved wrap, or with code 4, 5 or 6, is illegal. It raises `cfg_err_o` for exactly the next cycle, produces no beats, and ends any burst that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Column-access command: load a new burst |
| start_col_i | input | COL_W (8) | Starting column |
| blen_i | input | 3 | Burst length code: 0..3 give 1/2/4/8 beats, 7 gives full page |
| wrap_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | Burst stop |
| col_o | output | COL_W (8) | Column of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a bounded burst |
| cfg_err_o | output | 1 | Illegal burst setting seen at the last start |

## Verification
The bench builds the block with its default parameters: an 8-bit column and a largest bounded length of 8. The 8-bit column makes a full page small enough to run more than one complete wrap, including the roll-over from 255 to 0. With length 8 as the largest bounded burst, every legal length code and both wrap orders can be tried at start columns whose low bits are non-zero. The reference model recomputes each beat from arithmetic on the segment and compares it on every clock. This covers restarts, stops and illegal settings that arrive while a burst is still running.

// File: rtl/colgen_pkg.sv
`timescale 1ns/1ps
package colgen_pkg;
  typedef enum logic {WRAP_SEQ = 1'b0, WRAP_INTL = 1'b1} wrap_e;
  localparam logic [2:0] BLEN_FULL = 3'd7;
endpackage

// File: rtl/colgen_mask.sv
`timescale 1ns/1ps
// Decodes the burst length code into a segment mask (ones on moving bits).
module colgen_mask #(
  parameter int COL_W   = 8,
  parameter int MAX_LOG = 3
) (
  input  logic [2:0]       code_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             len_ok_o
);
  import colgen_pkg::*;

  assign full_o   = (code_i == BLEN_FULL);
  assign len_ok_o = full_o | (code_i <= 3'(MAX_LOG));

  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign mask_o[b] = full_o | (int'(code_i) > b);
  end
endmodule

// File: rtl/colgen_addr.sv
`timescale 1ns/1ps
// Forms the beat column from the held start column and the beat index.
module colgen_addr #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  colgen_pkg::wrap_e wrap_i,
  output logic [COL_W-1:0] col_o
);
  import colgen_pkg::*;

  logic [COL_W-1:0] low_seq;
  logic [COL_W-1:0] low_intl;

  always_comb begin
    low_seq  = (base_i + idx_i) & mask_i;
    low_intl = (base_i ^ idx_i) & mask_i;
    col_o    = (base_i & ~mask_i) | ((wrap_i == WRAP_INTL) ? low_intl : low_seq);
  end
endmodule

// File: rtl/colgen_seq.sv
`timescale 1ns/1ps
// Burst state: active flag, beat index, captured settings, error pulse.
module colgen_seq #(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              legal_i,
  input  logic [COL_W-1:0]  ld_col_i,
  input  logic [COL_W-1:0]  ld_mask_i,
  input  logic              ld_full_i,
  input  colgen_pkg::wrap_e ld_wrap_i,
  output logic              active_o,
  output logic [COL_W-1:0]  base_o,
  output logic [COL_W-1:0]  idx_o,
  output logic [COL_W-1:0]  mask_o,
  output logic              full_o,
  output colgen_pkg::wrap_e wrap_o,
  output logic              last_o,
  output logic              err_o
);
  import colgen_pkg::*;

  logic             active_q, active_d;
  logic [COL_W-1:0] idx_q, idx_d;
  logic [COL_W-1:0] base_q, mask_q;
  logic             full_q;
  wrap_e            wrap_q;
  logic             err_q, err_d;
  logic             load_en, last_c;

  assign last_c  = active_q & ~full_q & (idx_q == mask_q);
  assign load_en = start_i & legal_i;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    err_d    = start_i & ~legal_i;
    if (start_i) begin
      active_d = legal_i;
      idx_d    = '0;
    end else if (stop_i) begin
      active_d = 1'b0;
    end else if (active_q) begin
      if (last_c) active_d = 1'b0;
      else        idx_d    = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      wrap_q <= WRAP_SEQ;
    end else if (load_en) begin
      base_q <= ld_col_i;
      mask_q <= ld_mask_i;
      full_q <= ld_full_i;
      wrap_q <= ld_wrap_i;
    end
  end

  assign active_o = active_q;
  assign base_o   = base_q;
  assign idx_o    = idx_q;
  assign mask_o   = mask_q;
  assign full_o   = full_q;
  assign wrap_o   = wrap_q;
  assign last_o   = last_c;
  assign err_o    = err_q;

  // R5: a final beat is followed by silence unless restarted
  a_r5_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    last_c && !start_i |=> !active_q);
  // R9: an error pulse never coincides with a beat
  a_r9_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !active_q);
  // R9: illegal start yields an error pulse of one cycle
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(start_i && !legal_i) |=> !err_q);
endmodule

// File: rtl/sdram_burst_colgen.sv
`timescale 1ns/1ps
module sdram_burst_colgen #(
  parameter int COL_W   = 8,
  parameter int MAX_LOG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             wrap_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_valid_o,
  output logic             last_o,
  output logic             cfg_err_o
);
  import colgen_pkg::*;

  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] rst_sync_q;
  logic              core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[SYNC_W-1];

  logic [COL_W-1:0] ld_mask;
  logic             ld_full, len_ok, legal;
  wrap_e            ld_wrap;

  assign ld_wrap = wrap_e'(wrap_i);
  assign legal   = len_ok & ~(ld_full & (ld_wrap == WRAP_INTL));

  colgen_mask #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_mask (
    .code_i  (blen_i),
    .mask_o  (ld_mask),
    .full_o  (ld_full),
    .len_ok_o(len_ok)
  );

  logic [COL_W-1:0] base_q, idx_q, mask_q;
  logic             active_q, full_q;
  wrap_e            wrap_q;

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .legal_i  (legal),
    .ld_col_i (start_col_i),
    .ld_mask_i(ld_mask),
    .ld_full_i(ld_full),
    .ld_wrap_i(ld_wrap),
    .active_o (active_q),
    .base_o   (base_q),
    .idx_o    (idx_q),
    .mask_o   (mask_q),
    .full_o   (full_q),
    .wrap_o   (wrap_q),
    .last_o   (last_o),
    .err_o    (cfg_err_o)
  );

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .base_i(base_q),
    .idx_i (idx_q),
    .mask_i(mask_q),
    .wrap_i(wrap_q),
    .col_o (col_o)
  );

  assign beat_valid_o = active_q;

  // R2: legal start shows its column as beat 0 next cycle
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!core_rst_n)
    start_i && legal |=> beat_valid_o && col_o == $past(start_col_i));
  // R7: stop without start empties the burst
  a_r7_stop_ends: assert property (@(posedge clk) disable iff (!core_rst_n)
    stop_i && !start_i |=> !beat_valid_o);
  // R6: full page steps by one modulo the page
  a_r6_full_steps: assert property (@(posedge clk) disable iff (!core_rst_n)
    beat_valid_o && full_q && !start_i && !stop_i |=>
      beat_valid_o && col_o == $past(col_o) + COL_W'(1));
  // R3: bits above the segment hold through the burst
  a_r3_upper_held: assert property (@(posedge clk) disable iff (!core_rst_n)
    beat_valid_o && !last_o && !start_i && !stop_i |=>
      (col_o & ~mask_q) == ($past(col_o) & ~mask_q));
  // R5: final-beat flag only with a beat
  a_r5_last_valid: assert property (@(posedge clk) disable iff (!core_rst_n)
    last_o |-> beat_valid_o);
endmodule

// File: tb/test_sdram_burst_colgen.sv
`timescale 1ns/1ps
module test_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, wrap_i, stop_i;
  logic [7:0] start_col_i;
  logic [2:0] blen_i;
  logic [7:0] col_o;
  logic       beat_valid_o, last_o, cfg_err_o;

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .wrap_i(wrap_i), .stop_i(stop_i), .col_o(col_o),
    .beat_valid_o(beat_valid_o), .last_o(last_o), .cfg_err_o(cfg_err_o)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // reference state
  int m_active = 0, m_base = 0, m_n = 0, m_len = 1, m_full = 0, m_wrap = 0, m_err = 0;

  function automatic int exp_col();
    int len, seg, off;
    len = m_full ? 256 : m_len;
    seg = m_base - (m_base % len);
    if (m_wrap != 0) off = (m_base % len) ^ m_n;
    else             off = (m_base + m_n) % len;
    return seg + off;
  endfunction

  task automatic compare(string tag);
    bit bad = 0;
    int e_last;
    vectors++;
    e_last = (m_active != 0 && m_full == 0 && m_n == m_len - 1) ? 1 : 0;
    if (int'(beat_valid_o) != m_active) begin
      bad = 1; $display("FAIL %s valid actual=%0d expected=%0d", tag, beat_valid_o, m_active);
    end
    if (m_active != 0 && int'(col_o) != exp_col()) begin
      bad = 1; $display("FAIL %s col actual=%0d expected=%0d", tag, col_o, exp_col());
    end
    if (int'(last_o) != e_last) begin
      bad = 1; $display("FAIL %s last actual=%0d expected=%0d", tag, last_o, e_last);
    end
    if (int'(cfg_err_o) != m_err) begin
      bad = 1; $display("FAIL %s err actual=%0d expected=%0d", tag, cfg_err_o, m_err);
    end
    if (bad) miscompares++;
  endtask

  task automatic step(input bit st, input int col, input int code, input bit wr,
                      input bit sp, input string tag);
    start_i = st; start_col_i = 8'(col); blen_i = 3'(code); wrap_i = wr; stop_i = sp;
    m_err = 0;
    if (st) begin
      if (code <= 3 || (code == 7 && wr == 0)) begin
        m_active = 1; m_base = col; m_n = 0; m_wrap = wr;
        m_full = (code == 7) ? 1 : 0;
        m_len = m_full ? 256 : (1 << code);
      end else begin
        m_active = 0; m_err = 1;
      end
    end else if (sp) begin
      m_active = 0;
    end else if (m_active != 0) begin
      if (m_full == 0 && m_n == m_len - 1) m_active = 0;
      else m_n = (m_n + 1) % 256;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int k, input string tag);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 0; start_col_i = 0; blen_i = 0; wrap_i = 0; stop_i = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    idle(4, "R1");

    // R2 / R5: every bounded length, sequential
    for (int c = 0; c < 4; c++) begin
      step(1, 8'h35, c, 0, 0, "R2");
      idle((1 << c) + 1, "R5");
    end
    // R3: sequential wrap inside segment
    step(1, 8'h4E, 2, 0, 0, "R3");
    idle(5, "R3");
    step(1, 8'hBB, 3, 0, 0, "R3");
    idle(9, "R3");
    // R4: interleaved orders
    step(1, 8'h02, 3, 1, 0, "R4");
    idle(9, "R4");
    step(1, 8'h9D, 2, 1, 0, "R4");
    idle(5, "R4");
    step(1, 8'h77, 1, 1, 0, "R4");
    idle(3, "R4");
    // R6: full page through roll-over and a whole wrap, then R7 stop
    step(1, 8'hFC, 7, 0, 0, "R6");
    idle(300, "R6");
    step(0, 0, 0, 0, 1, "R7");
    idle(3, "R7");
    // R7: stop mid bounded burst
    step(1, 8'h60, 3, 1, 0, "R7");
    idle(3, "R7");
    step(0, 0, 0, 0, 1, "R7");
    idle(4, "R7");
    // R8: restart mid burst, and start with stop together
    step(1, 8'h10, 3, 0, 0, "R8");
    idle(4, "R8");
    step(1, 8'hA5, 3, 1, 0, "R8");
    idle(3, "R8");
    step(1, 8'h3F, 2, 0, 1, "R8");
    idle(6, "R8");
    // R9: illegal settings, one during a running burst
    step(1, 8'h20, 3, 0, 0, "R9");
    idle(2, "R9");
    step(1, 8'h44, 7, 1, 0, "R9");
    idle(3, "R9");
    step(1, 8'h44, 5, 0, 0, "R9");
    step(1, 8'h44, 4, 1, 0, "R9");
    idle(3, "R9");
    step(1, 8'h81, 0, 1, 0, "R2");
    idle(3, "R2");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule